// File: doc/BRIEF.md
# Translation Buffer Array Access Port

This block is a bus slave that gives software direct read and write access to the entries of two translation buffers. One is a small 4-entry buffer for instruction fetches. The other is a 64-entry unified buffer. Each buffer appears as two arrays: an address array and a data array.

An address array entry holds the virtual page number, the address-space identifier and the valid and dirty flags. A data array entry holds the physical page number and the attribute flags. Each unified entry also has a 4-bit secondary word. The entry is picked by fixed address bits. Fields are packed into and unpacked from a 32-bit word. The dirty flag is moved between bus bit 9 and internal flag bit 2.

Accesses to the cache array regions complete normally and read as zero. Every request gets a response one cycle later.

Internal flag encoding (bit positions):

| Flag | Bit |
|------|-----|
| write-through | 0 |
| shared | 1 |
| dirty | 2 |
| cacheable | 3 |
| page size | 7 and 4 (00 = 1K, 01 = 4K, 10 = 64K, 11 = 1M) |
| writable | 5 |
| user-accessible | 6 |
| valid | 8 |

Top module: `tlb_array_port`

## Requirements
- R1: After reset every entry is zero, so any read returns 0, and rspValid stays low while no request is made.
- R2: A request with reqValid high in one cycle gives rspValid high in the next cycle, with that read's data on rspRdata. rspValid is low in every other cycle.
- R3: reqAddr[26:24] selects the region: 2 = instruction address array, 3 = instruction data array, 6 = unified address array, 7 = unified data array. Values 0, 1, 4 and 5 are cache arrays.
- R4: The instruction entry index is reqAddr[8:7] (4 entries). The unified entry index is reqAddr[13:8] (64 entries). Other address bits do not change which entry is reached.
- R5: An instruction address array write stores VPN from bits 31:10, ASID from bits 7:0 and the valid flag from bit 8. It leaves all other flags of that entry unchanged. A read returns VPN | valid<<8 | ASID.
- R6: An instruction data array write stores PPN from bits 28:10 and the flags masked with 0x1DA. A read returns PPN<<10 | flags.
- R7: A unified address array write with reqAddr[7]=0 stores VPN and ASID, bus bit 8 as valid and bus bit 9 as dirty (flag bit 2). A read returns VPN | dirty<<9 | valid<<8 | ASID.
- R8: A unified address array write with reqAddr[7]=1 (associative mode) changes no entry.
- R9: In the unified data array, reqAddr[23]=1 reaches the 4-bit secondary word (bits 3:0; a read returns upper bits zero). reqAddr[23]=0 reaches PPN (bits 28:10) and flags (bits 8:0).
- R10: Cache array reads return 0, and cache array writes change no translation entry.
- R11: The response to a write carries rspRdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Access address (region, entry index, mode bits) |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 32 | Read data (zero for writes) |

## Verification
The hardest situation to reach from the ports is an update that must change one field of an entry and keep the rest. Two cases matter here:
- an instruction address write that clears only the valid flag;
- a unified data write that changes the dirty flag, which is then seen through the address array at a different bit.

The bench first fills an entry with all flags set through the data array. It then rewrites the entry through the address array and reads both views back.

It also sends an associative write, a secondary-word write and writes to the cache regions aimed at an entry that is already loaded. It then reads that entry back to show nothing else moved. Aliasing addresses with bits set outside the index field show that the index decode is exact.

// File: rtl/tlb_array_port_pkg.sv
package tlb_array_port_pkg;
  localparam int VPN_LSB  = 10;
  localparam int VPN_W    = 22;
  localparam int PPN_LSB  = 10;
  localparam int PPN_W    = 19;
  localparam int ASID_W   = 8;
  localparam int FLAG_W   = 9;
  localparam int SEC_W    = 4;
  localparam int VALID_BIT = 8;
  localparam int DIRTY_BIT = 2;
  localparam int BUS_DIRTY = 9;
  localparam logic [FLAG_W-1:0] IDATA_MASK = 9'h1DA;

  localparam logic [2:0] RG_IADDR = 3'd2;
  localparam logic [2:0] RG_IDATA = 3'd3;
  localparam logic [2:0] RG_UADDR = 3'd6;
  localparam logic [2:0] RG_UDATA = 3'd7;

  typedef enum logic [2:0] {
    RD_ZERO, RD_IADDR, RD_IDATA, RD_UADDR, RD_UDATA, RD_USEC
  } rdSel_e;

  typedef struct packed {
    logic   rsp;
    logic   iAddrWr;
    logic   iDataWr;
    logic   uAddrWr;
    logic   uDataWr;
    logic   uSecWr;
    rdSel_e rdSel;
    logic [5:0] uIdx;
    logic [1:0] iIdx;
  } strobe_t;
endpackage

// File: rtl/tlb_array_port_ctrl.sv
module tlb_array_port_ctrl
  import tlb_array_port_pkg::*;
#(
  parameter int I_ENTRIES = 4,
  parameter int U_ENTRIES = 64,
  parameter int I_IDX_LSB = 7,
  parameter int U_IDX_LSB = 8,
  parameter int ASSOC_BIT = 7,
  parameter int SEC_BIT   = 23,
  parameter int RG_LSB    = 24
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  output strobe_t     stb
);
  localparam int I_IDX_W = $clog2(I_ENTRIES);
  localparam int U_IDX_W = $clog2(U_ENTRIES);

  logic [2:0] region;
  logic       rd;
  logic       wr;
  logic       unusedAddr;

  assign region = reqAddr[RG_LSB +: 3];
  assign rd = reqValid && !reqWrite;
  assign wr = reqValid && reqWrite;
  assign unusedAddr = ^{reqAddr[31:RG_LSB+3], reqAddr[RG_LSB-1:0]};

  always_comb begin
    stb = '0;
    stb.rsp  = reqValid;
    stb.iIdx = 2'(reqAddr[I_IDX_LSB +: I_IDX_W]);
    stb.uIdx = 6'(reqAddr[U_IDX_LSB +: U_IDX_W]);
    stb.rdSel = RD_ZERO;
    case (region)
      RG_IADDR: begin
        stb.iAddrWr = wr;
        if (rd) stb.rdSel = RD_IADDR;
      end
      RG_IDATA: begin
        stb.iDataWr = wr;
        if (rd) stb.rdSel = RD_IDATA;
      end
      RG_UADDR: begin
        stb.uAddrWr = wr && !reqAddr[ASSOC_BIT];
        if (rd) stb.rdSel = RD_UADDR;
      end
      RG_UDATA: begin
        stb.uDataWr = wr && !reqAddr[SEC_BIT];
        stb.uSecWr  = wr && reqAddr[SEC_BIT];
        if (rd) stb.rdSel = reqAddr[SEC_BIT] ? RD_USEC : RD_UDATA;
      end
      default: stb.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/tlb_array_port_dp.sv
module tlb_array_port_dp
  import tlb_array_port_pkg::*;
#(
  parameter int I_ENTRIES = 4,
  parameter int U_ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata
);
  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } entry_t;

  entry_t iTab [I_ENTRIES];
  entry_t uTab [U_ENTRIES];
  logic [SEC_W-1:0] uSec [U_ENTRIES];

  logic [31:0] rdMux;
  entry_t iSel;
  entry_t uSel;

  assign iSel = iTab[stb.iIdx];
  assign uSel = uTab[stb.uIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < I_ENTRIES; i++) iTab[i] <= '0;
      for (int u = 0; u < U_ENTRIES; u++) begin
        uTab[u] <= '0;
        uSec[u] <= '0;
      end
    end else begin
      if (stb.iAddrWr) begin
        iTab[stb.iIdx].vpn  <= reqWdata[VPN_LSB +: VPN_W];
        iTab[stb.iIdx].asid <= reqWdata[ASID_W-1:0];
        iTab[stb.iIdx].flags[VALID_BIT] <= reqWdata[VALID_BIT];
      end
      if (stb.iDataWr) begin
        iTab[stb.iIdx].ppn   <= reqWdata[PPN_LSB +: PPN_W];
        iTab[stb.iIdx].flags <= reqWdata[FLAG_W-1:0] & IDATA_MASK;
      end
      if (stb.uAddrWr) begin
        uTab[stb.uIdx].vpn  <= reqWdata[VPN_LSB +: VPN_W];
        uTab[stb.uIdx].asid <= reqWdata[ASID_W-1:0];
        uTab[stb.uIdx].flags[VALID_BIT] <= reqWdata[VALID_BIT];
        uTab[stb.uIdx].flags[DIRTY_BIT] <= reqWdata[BUS_DIRTY];
      end
      if (stb.uDataWr) begin
        uTab[stb.uIdx].ppn   <= reqWdata[PPN_LSB +: PPN_W];
        uTab[stb.uIdx].flags <= reqWdata[FLAG_W-1:0];
      end
      if (stb.uSecWr) uSec[stb.uIdx] <= reqWdata[SEC_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdSel)
      RD_IADDR: begin
        rdMux[VPN_LSB +: VPN_W] = iSel.vpn;
        rdMux[ASID_W-1:0]       = iSel.asid;
        rdMux[VALID_BIT]        = iSel.flags[VALID_BIT];
      end
      RD_IDATA: begin
        rdMux[PPN_LSB +: PPN_W] = iSel.ppn;
        rdMux[FLAG_W-1:0]       = iSel.flags;
      end
      RD_UADDR: begin
        rdMux[VPN_LSB +: VPN_W] = uSel.vpn;
        rdMux[ASID_W-1:0]       = uSel.asid;
        rdMux[VALID_BIT]        = uSel.flags[VALID_BIT];
        rdMux[BUS_DIRTY]        = uSel.flags[DIRTY_BIT];
      end
      RD_UDATA: begin
        rdMux[PPN_LSB +: PPN_W] = uSel.ppn;
        rdMux[FLAG_W-1:0]       = uSel.flags;
      end
      RD_USEC: rdMux[SEC_W-1:0] = uSec[stb.uIdx];
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= stb.rsp;
      rspRdata <= rdMux;
    end
  end
endmodule

// File: rtl/tlb_array_port.sv
module tlb_array_port
  import tlb_array_port_pkg::*;
#(
  parameter int I_ENTRIES = 4,
  parameter int U_ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata
);
  strobe_t stb;

  tlb_array_port_ctrl #(.I_ENTRIES(I_ENTRIES), .U_ENTRIES(U_ENTRIES)) ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .stb(stb)
  );

  tlb_array_port_dp #(.I_ENTRIES(I_ENTRIES), .U_ENTRIES(U_ENTRIES)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/tlb_array_port_chk.sv
module tlb_array_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic        rspValid,
  input logic [31:0] rspRdata
);
  logic cacheRegion;
  assign cacheRegion = (reqAddr[26:24] == 3'd0) || (reqAddr[26:24] == 3'd1) ||
                       (reqAddr[26:24] == 3'd4) || (reqAddr[26:24] == 3'd5);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r11_write_rdata_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == 32'h0));
  a_r10_cache_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && cacheRegion) |=> (rspRdata == 32'h0));
  a_r6_idata_mask: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr[26:24] == 3'd3) |=> ((rspRdata & 32'hE0000225) == 32'h0));
  a_r9_sec_width: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr[26:24] == 3'd7 && reqAddr[23]) |=> (rspRdata[31:4] == 28'h0));
endmodule

bind tlb_array_port tlb_array_port_chk chk (.*);

// File: tb/tlb_array_port_test.sv
`timescale 1ns/1ps
module tlb_array_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_array_port uut (.*);

  function automatic logic [31:0] aI(input logic [2:0] rg, input int idx);
    return 32'hF000_0000 | (32'(rg) << 24) | (32'(idx) << 7);
  endfunction
  function automatic logic [31:0] aU(input logic [2:0] rg, input int idx);
    return 32'hF000_0000 | (32'(rg) << 24) | (32'(idx) << 8);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
    check("R2 write rspValid", 32'(rspValid), 32'h1);
    check("R11 write rdata", rspRdata, 32'h0);
  endtask

  task automatic busRead(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check("R2 read rspValid", 32'(rspValid), 32'h1);
    d = rspRdata;
  endtask

  task automatic readExpect(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic tReset();
    repeat (2) @(negedge clk);
    check("R1 idle rspValid", 32'(rspValid), 32'h0);
    readExpect("R1 iaddr zero", aI(3'd2, 0), 32'h0);
    readExpect("R1 udata zero", aU(3'd7, 63), 32'h0);
    @(negedge clk);
    check("R2 no rsp when idle", 32'(rspValid), 32'h0);
  endtask

  task automatic tItlb();
    busWrite(aI(3'd2, 2), 32'hABCD_E7FF);
    readExpect("R5 iaddr readback", aI(3'd2, 2), 32'hABCD_E5FF);
    readExpect("R4 i other entry", aI(3'd2, 1), 32'h0);
    busWrite(aI(3'd3, 2), 32'hFFFF_FFFF);
    readExpect("R6 idata mask", aI(3'd3, 2), 32'h1FFF_FDDA);
    busWrite(aI(3'd2, 2), 32'h1111_1022);
    readExpect("R5 valid only cleared", aI(3'd3, 2), 32'h1FFF_FCDA);
    readExpect("R5 iaddr new", aI(3'd2, 2), 32'h1111_1022);
    readExpect("R4 i alias bits", aI(3'd2, 2) | 32'h0000_0C00, 32'h1111_1022);
  endtask

  task automatic tUtlb();
    busWrite(aU(3'd6, 37), 32'h1234_5B42);
    readExpect("R7 uaddr dirty valid", aU(3'd6, 37), 32'h1234_5B42);
    readExpect("R7 dirty at flag bit2", aU(3'd7, 37), 32'h0000_0104);
    busWrite(aU(3'd7, 37), 32'hF555_5500);
    readExpect("R9 primary data", aU(3'd7, 37), 32'h1555_5500);
    readExpect("R7 dirty cleared", aU(3'd6, 37), 32'h1234_5942);
    readExpect("R3 iaddr distinct", aI(3'd2, 2), 32'h1111_1022);
    readExpect("R4 u other entry", aU(3'd6, 36), 32'h0);
    readExpect("R4 u alias bits", aU(3'd6, 37) | 32'h0000_C07F, 32'h1234_5942);
  endtask

  task automatic tAssoc();
    busWrite(aU(3'd6, 37) | 32'h80, 32'h0000_0000);
    readExpect("R8 assoc ignored", aU(3'd6, 37), 32'h1234_5942);
  endtask

  task automatic tSecondary();
    busWrite(aU(3'd7, 37) | 32'h0080_0000, 32'hFFFF_FFF9);
    readExpect("R9 secondary", aU(3'd7, 37) | 32'h0080_0000, 32'h9);
    readExpect("R9 primary kept", aU(3'd7, 37), 32'h1555_5500);
  endtask

  task automatic tCache();
    for (int r = 0; r < 8; r++) begin
      if (r == 0 || r == 1 || r == 4 || r == 5)
        busWrite(aU(3'(r), 37) | 32'h100, 32'hFFFF_FFFF);
    end
    for (int r = 0; r < 8; r++) begin
      if (r == 0 || r == 1 || r == 4 || r == 5)
        readExpect("R10 cache read zero", aU(3'(r), 37), 32'h0);
    end
    readExpect("R10 uaddr untouched", aU(3'd6, 37), 32'h1234_5942);
    readExpect("R10 udata untouched", aU(3'd7, 37), 32'h1555_5500);
    readExpect("R10 idata untouched", aI(3'd3, 2), 32'h1FFF_FCDA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tItlb();
    tUtlb();
    tAssoc();
    tSecondary();
    tCache();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule